// File: doc/BRIEF.md
# Voltage Regulator Reference Sequencer

This block produces the digital reference code that a regulator's error amplifier tracks. It handles power-up, the wait for the first voltage command, slewing to commanded levels, and a soft shutdown ramp. Commands arrive already decoded as a target code with a one-cycle valid strobe. The reference is an unsigned code with 6.25 mV per LSB.

A tick with a period of one microsecond is derived from the system clock by dividing it by `TICK_DIV`. All ramp steps and the zero-branch hold timer advance on this tick. The divider restarts each time a sequence begins, so timing is measured from the start.

Start-up takes one of two branches. A zero initial level holds the reference at 0 for a fixed time. A nonzero initial level ramps up at once. In both branches, ready is raised only when a commanded target has been reached. When enable drops, the reference falls at half an LSB per tick. Once it goes below the cutoff code, the drivers are disabled.

Top module: `vr_ref_sequencer`

## Requirements
- R1: While por_good_i and en_i are not both high, the block stays off: ref_code_o is 0, drv_en_o is 0 and ready_o is 0. A sequence starts on the first clock edge at which both are high, and from that edge drv_en_o is 1.
- R2: init_sel_i is sampled at start and selects the initial code: 0 selects 0 V (code 0), 1 selects 0.9 V (144), 2 selects 1.0 V (160), 3 selects 1.1 V (176), 4 selects 1.5 V (240). Values 5 to 7 select 0 V.
- R3: With a 0 V initial level, the reference stays at 0 for HOLD_US ticks and commands in that window are ignored. Afterwards the block waits at 0 for a command.
- R4: With a nonzero initial level, the reference rises from 0 at once, by SLEW_STEP codes per tick. It stops exactly at the initial code and stays there with ready_o low until a command arrives.
- R5: A command moves the reference toward cmd_code_i, up or down, by at most SLEW_STEP codes per tick. The last step is clamped, so the target is never passed.
- R6: ready_o rises once the reference equals the commanded target, and stays high while enabled and no new command arrives.
- R7: A command accepted during a ramp, or while ready, retargets at once. ready_o is low from the next edge until the new target is reached.
- R8: When en_i falls, ready_o goes low in the same cycle. The reference then falls by one code every two ticks (3.125 mV per microsecond).
- R9: During shutdown, once the reference is below code 32 (0.2 V), drv_en_o goes low and the reference is forced to 0 on the next edge.
- R10: If en_i returns during shutdown, the ramp still runs to the cutoff. A new sequence starts only after drv_en_o has gone low.
- R11: When por_good_i falls, ready_o goes low in the same cycle. On the next edge the block is off, with ref_code_o at 0 and drv_en_o at 0, with no ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_good_i | input | 1 | Supplies-good flag |
| en_i | input | 1 | Regulator enable |
| init_sel_i | input | 3 | Initial level select |
| cmd_valid_i | input | 1 | One-cycle strobe for a voltage command |
| cmd_code_i | input | 8 | Commanded target code, 6.25 mV/LSB |
| ref_code_o | output | 8 | Current reference code |
| ready_o | output | 1 | Reference has reached the commanded target |
| drv_en_o | output | 1 | Power-stage drivers enabled |

## Verification
The assertions assume that cmd_code_i is held only during a valid strobe and that init_sel_i is stable when a sequence starts. The stimulus changes inputs only on falling clock edges and keeps commands one cycle long. The assertions also assume that TICK_DIV is at least two, so that a step is followed by idle cycles. The bench shortens the tick divider and the hold time, and it spaces commands by many cycles so that each ramp can be observed in full.

// File: rtl/vr_ref_sequencer.sv
`timescale 1ns/1ps
module vr_ref_sequencer #(
  parameter int W         = 8,
  parameter int TICK_DIV  = 200,
  parameter int HOLD_US   = 2000,
  parameter int SLEW_STEP = 2,
  parameter int CUTOFF    = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         por_good_i,
  input  logic         en_i,
  input  logic [2:0]   init_sel_i,
  input  logic         cmd_valid_i,
  input  logic [W-1:0] cmd_code_i,
  output logic [W-1:0] ref_code_o,
  output logic         ready_o,
  output logic         drv_en_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int HW = $clog2(HOLD_US + 1);

  typedef enum logic [2:0] {S_OFF, S_HOLD, S_RAMPI, S_WAIT, S_SLEW, S_READY, S_SHUT} st_e;

  st_e            st_q;
  logic [W-1:0]   ref_q, tgt_q;
  logic           half_q;
  logic [DW-1:0]  div_q;
  logic [HW-1:0]  hold_q;
  logic           tick;
  logic [W-1:0]   init_code, ref_next;

  assign tick = (div_q == DW'(TICK_DIV - 1));

  always_comb begin
    case (init_sel_i)
      3'd1:    init_code = W'(144);
      3'd2:    init_code = W'(160);
      3'd3:    init_code = W'(176);
      3'd4:    init_code = W'(240);
      default: init_code = '0;
    endcase
  end

  always_comb begin
    if (ref_q < tgt_q)
      ref_next = ((tgt_q - ref_q) > W'(SLEW_STEP)) ? ref_q + W'(SLEW_STEP) : tgt_q;
    else if (ref_q > tgt_q)
      ref_next = ((ref_q - tgt_q) > W'(SLEW_STEP)) ? ref_q - W'(SLEW_STEP) : tgt_q;
    else
      ref_next = ref_q;
  end

  wire cmd_ok = cmd_valid_i && (st_q == S_RAMPI || st_q == S_WAIT ||
                                st_q == S_SLEW  || st_q == S_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_OFF;
      ref_q  <= '0;
      tgt_q  <= '0;
      half_q <= 1'b0;
      div_q  <= '0;
      hold_q <= '0;
    end else begin
      div_q <= (st_q == S_OFF || tick) ? '0 : div_q + 1'b1;
      if (!por_good_i) begin
        st_q   <= S_OFF;
        ref_q  <= '0;
        half_q <= 1'b0;
      end else if (!en_i && st_q != S_OFF && st_q != S_SHUT) begin
        st_q   <= S_SHUT;
        half_q <= 1'b0;
      end else if (cmd_ok) begin
        tgt_q <= cmd_code_i;
        st_q  <= S_SLEW;
      end else begin
        case (st_q)
          S_OFF: if (en_i) begin
            tgt_q  <= init_code;
            hold_q <= '0;
            st_q   <= (init_code == '0) ? S_HOLD : S_RAMPI;
          end
          S_HOLD: if (tick) begin
            if (hold_q == HW'(HOLD_US - 1)) st_q <= S_WAIT;
            else hold_q <= hold_q + 1'b1;
          end
          S_RAMPI: begin
            if (ref_q == tgt_q) st_q <= S_WAIT;
            else if (tick) ref_q <= ref_next;
          end
          S_SLEW: begin
            if (ref_q == tgt_q) st_q <= S_READY;
            else if (tick) ref_q <= ref_next;
          end
          S_SHUT: begin
            if (ref_q < W'(CUTOFF)) begin
              st_q  <= S_OFF;
              ref_q <= '0;
            end else if (tick) begin
              {ref_q, half_q} <= {ref_q, half_q} - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ref_code_o = ref_q;
  assign ready_o    = (st_q == S_READY) && por_good_i && en_i;
  assign drv_en_o   = (st_q != S_OFF);

  p_ready_at_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (ref_code_o == tgt_q));
  p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HOLD) |-> (ref_code_o == '0));
  p_ramp_no_overshoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RAMPI) |-> (ref_code_o <= tgt_q));
  p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_SLEW || st_q == S_RAMPI) && $past(st_q == S_SLEW || st_q == S_RAMPI)) |->
      (((ref_q >= $past(ref_q)) ? (ref_q - $past(ref_q)) : ($past(ref_q) - ref_q)) <= W'(SLEW_STEP)));
  p_shut_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SHUT && $past(st_q == S_SHUT)) |->
      (ref_q <= $past(ref_q) && ($past(ref_q) - ref_q) <= W'(1)));
  p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en_o |-> (ref_code_o == '0));
endmodule

// File: tb/tb_vr_ref_sequencer.sv
`timescale 1ns/1ps
module tb_vr_ref_sequencer;
  localparam int TD = 4, HOLD = 50, STEP = 2;
  logic clk = 0, rst_n = 0, por = 0, en = 0, cv = 0;
  logic [2:0] sel = 0;
  logic [7:0] cc = 0, ref_c;
  logic rdy, drv;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  vr_ref_sequencer #(.W(8), .TICK_DIV(TD), .HOLD_US(HOLD), .SLEW_STEP(STEP), .CUTOFF(32)) dut (
    .clk(clk), .rst_n(rst_n), .por_good_i(por), .en_i(en), .init_sel_i(sel),
    .cmd_valid_i(cv), .cmd_code_i(cc), .ref_code_o(ref_c), .ready_o(rdy), .drv_en_o(drv));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] code);
    @(negedge clk); cv = 1; cc = code;
    @(negedge clk); cv = 0; cc = 0;
  endtask

  // wait until ref == v; report max seen and whether ready rose early
  task automatic wait_ref(input logic [7:0] v, input int lim, output int maxv, output int early);
    maxv = 0; early = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (ref_c > maxv) maxv = ref_c;
      if (rdy && ref_c != v) early = 1;
      if (ref_c == v) break;
    end
  endtask

  task automatic shut_off();
    @(negedge clk); en = 0;
    for (int i = 0; i < 3000 && drv; i++) @(negedge clk);
    cyc(2);
  endtask

  task automatic t_no_start();
    chk("R1 reset ref", ref_c, 0); chk("R1 reset drv", drv, 0); chk("R1 reset rdy", rdy, 0);
    en = 1; por = 0; cyc(50);
    chk("R1 en only drv", drv, 0); chk("R1 en only ref", ref_c, 0);
    en = 0; por = 1; cyc(50);
    chk("R1 por only drv", drv, 0); chk("R1 por only rdy", rdy, 0);
  endtask

  task automatic t_zero_branch();
    int mx, early;
    sel = 3'd0; @(negedge clk); en = 1;
    cyc(2); chk("R1 drv on", drv, 1);
    cyc(90);
    send(8'd160);
    cyc(300);
    chk("R3 ignored cmd ref", ref_c, 0); chk("R3 ignored cmd rdy", rdy, 0); chk("R3 drv", drv, 1);
    send(8'd160);
    wait_ref(8'd160, 1000, mx, early);
    cyc(2);
    chk("R5 reach 160", ref_c, 160); chk("R5 no overshoot", mx, 160);
    chk("R6 no early ready", early, 0); chk("R6 ready", rdy, 1);
  endtask

  task automatic t_shutdown();
    int n = 0, last = 255, mono = 1, prev = 255;
    @(negedge clk); en = 0; #1;
    chk("R8 ready drops same cycle", rdy, 0);
    while (drv && n < 3000) begin
      @(negedge clk); n++;
      if (ref_c > prev) mono = 0;
      prev = ref_c;
      if (drv) last = ref_c;
    end
    chk("R8 monotonic fall", mono, 1);
    chk("R8 shutdown time in window", (n >= 1020 && n <= 1040), 1);
    chk("R9 cutoff level", last, 31);
    chk("R9 ref zero after off", ref_c, 0);
  endtask

  task automatic t_init_codes();
    int expv[8] = '{0, 144, 160, 176, 240, 0, 0, 0};
    int mx, early;
    for (int s = 1; s < 8; s++) begin
      sel = 3'(s); @(negedge clk); en = 1;
      cyc(20);
      if (s <= 4) chk($sformatf("R4 rising sel%0d", s), ref_c > 0, 1);
      else chk($sformatf("R3 held zero sel%0d", s), ref_c, 0);
      cyc(600);
      chk($sformatf("R2 init code sel%0d", s), ref_c, expv[s]);
      chk($sformatf("R4 no ready sel%0d", s), rdy, 0);
      if (s == 1) begin
        send(8'd151);
        wait_ref(8'd151, 200, mx, early); cyc(2);
        chk("R5 clamp 151", ref_c, 151); chk("R5 clamp max", mx, 151); chk("R6 ready 151", rdy, 1);
        send(8'd100);
        wait_ref(8'd100, 400, mx, early); cyc(2);
        chk("R5 down 100", ref_c, 100); chk("R6 early down", early, 0); chk("R6 ready 100", rdy, 1);
        send(8'd240); cyc(40);
        chk("R7 midramp no ready", rdy, 0);
        send(8'd170);
        wait_ref(8'd170, 400, mx, early); cyc(2);
        chk("R7 retarget reached", ref_c, 170); chk("R7 no overshoot", mx <= 170, 1);
        chk("R7 no early ready", early, 0); chk("R7 ready", rdy, 1);
        send(8'd180);
        chk("R7 ready drops on new cmd", rdy, 0);
        wait_ref(8'd180, 200, mx, early); cyc(2);
        chk("R7 ready 180", rdy, 1);
      end
      shut_off();
      chk($sformatf("R9 off sel%0d", s), drv, 0);
    end
  endtask

  task automatic t_por_drop();
    int mx, early;
    sel = 3'd2; @(negedge clk); en = 1; cyc(400);
    send(8'd160); cyc(10);
    chk("R6 ready before por drop", rdy, 1);
    @(negedge clk); por = 0; #1;
    chk("R11 ready drops same cycle", rdy, 0);
    @(negedge clk);
    chk("R11 drv off", drv, 0); chk("R11 ref zero", ref_c, 0);
    por = 1; cyc(2);
    chk("R11 restart", drv, 1);
    wait_ref(8'd160, 600, mx, early);
    shut_off();
  endtask

  task automatic t_en_return();
    int mx, early, n = 0;
    sel = 3'd2; @(negedge clk); en = 1;
    wait_ref(8'd160, 600, mx, early);
    cyc(4);
    @(negedge clk); en = 0; cyc(200);
    en = 1; cyc(4);
    chk("R10 still shutting", drv, 1);
    chk("R10 ref below start", ref_c < 160, 1);
    while (drv && n < 3000) begin @(negedge clk); n++; end
    chk("R10 drivers went off", drv, 0);
    cyc(2);
    chk("R10 restarted after off", drv, 1);
    shut_off();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    t_no_start();
    t_zero_branch();
    t_shutdown();
    t_init_codes();
    t_por_drop();
    t_en_return();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule